// File: doc/BRIEF.md
# Watchdog Supervisor with Start Delay

This block watches for a periodic sign of life from the rest of the system. A kick is either a change of level on an asynchronous watchdog pin (rising or falling) or a one-cycle command strobe from a management register interface. A free-running 1 ms tick input paces all timing. If a programmed number of ticks passes with no kick, the block raises its reset-request output for a fixed number of ticks. It then stays silent until a new kick re-arms it.

Monitoring can start in the first clock after reset or enable. It can also start after an initial wait taken from a doubling ladder of nine lengths between 100 ms and 25.6 s. While that wait runs, kicks have no effect. A status output shows when the wait is over and supervision is live. Dropping the enable stops everything. Raising it again begins a fresh wait.

Top module: `wdog_supervisor`

## Requirements
- R1: While the synchronous active-low reset is low, and on the first sample after it, `wdo` and `monitor_active` are 0.
- R2: With `delay_sel` = 0, `monitor_active` rises after the first enabled clock, and period counting covers only ticks that come after that clock.
- R3: With no kick, `wdo` rises in the cycle after the clock that takes the `period_ms`-th tick following the last kick or the start of monitoring.
- R4: Both a rising and a falling change of `wdi` count as a kick. `wdi` passes through a two-flop synchronizer, so a change takes effect on the third clock edge after it is applied.
- R5: A one-cycle `kick_cmd` has the same effect as a `wdi` change, and it takes effect on the next clock edge.
- R6: `wdo` is active high and stays high for exactly PULSE_TICKS ticks (parameter, default 1), then returns low.
- R7: After a pulse, `wdo` stays low for any length of time until a kick arrives. That kick restarts a full period.
- R8: A kick presented in the same cycle as the tick that would complete the period wins: no pulse is emitted, and a new full period starts.
- R9: `delay_sel` codes 1 to 9 give a wait of 100·2^(code−1) ticks, and codes 10 to 15 act as 9. `monitor_active` rises in the cycle after the clock that takes the last wait tick.
- R10: Kicks (pin or command) that arrive during the initial wait are ignored, so the first expiry falls at wait end plus `period_ms` ticks.
- R11: With `enable` low, `wdo` and `monitor_active` are 0 from the next clock, even during a pulse. Raising `enable` again restarts the initial wait.
- R12: A `period_ms` of 0 behaves as a period of 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_1ms | input | 1 | One-cycle pulse per millisecond |
| wdi | input | 1 | Asynchronous watchdog pin; any change is a kick |
| kick_cmd | input | 1 | One-cycle kick strobe from the register interface |
| enable | input | 1 | Supervision enable; low clears the block |
| period_ms | input | 18 | Timeout period in ticks (0 acts as 1) |
| delay_sel | input | 4 | Initial wait select code |
| wdo | output | 1 | Reset-request pulse, active high |
| monitor_active | output | 1 | High once the initial wait is over |

## Verification
The timeout path is exercised with four stimulus patterns. Command strobes alone show the basic period. A rising and then a falling pin change, placed so that missing either edge would move the expiry earlier, shows that both edges count. A strobe lined up exactly on the expiring tick tells the kick-priority rule apart from a late kick. A zero period checks the clamp. The start path runs immediate start, codes 1 and 3, and the clamped code 12. Kicks are injected inside the wait, so that an expiry measured from a kick and one measured from the wait end land on different ticks. The bench also disables the block in the middle of a pulse, and it stays silent through a long idle stretch after a pulse.

// File: rtl/wdog_pkg.sv
// Package: shared state encoding and the start-wait ladder for the watchdog.
// Assumes the ladder base and top code are passed in by the user modules.
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,   // initial wait or disabled
        ST_RUN   = 2'd1,   // counting the timeout period
        ST_PULSE = 2'd2,   // driving the reset-request pulse
        ST_HOLD  = 2'd3    // expired, silent until the next kick
    } wd_state_t;

    // Clamp a select code to the highest ladder step.
    function automatic int unsigned clamp_code(input int unsigned code,
                                               input int unsigned max_code);
        return (code > max_code) ? max_code : code;
    endfunction

endpackage

// File: rtl/wdog_sync_edge.sv
// Module: brings the asynchronous watchdog pin into the clock domain and
// flags every change of level (both directions) as a one-cycle pulse.
// Assumes STAGES >= 2. A change applied before clock edge k is reported
// in the cycle between edges k+STAGES-1 and k+STAGES.
module wdog_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic change_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchronizer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Any difference between the settled sample and its predecessor is a kick.
    always_comb change_o = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/wdog_start_delay.sv
// Module: times the initial wait after reset or enable. The wait length
// follows a doubling ladder picked by a select code; code 0 means no wait.
// wait_over is high from the clock that takes the last wait tick onward,
// so the timer can leave its wait state on that same edge.
// Assumes clear is held high whenever supervision is disabled.
module wdog_start_delay #(
    parameter int SEL_W    = 4,
    parameter int BASE     = 100,
    parameter int MAX_CODE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             wait_over
);
    import wdog_pkg::*;

    localparam int LONGEST = BASE << (MAX_CODE - 1);
    localparam int LIM_W   = $clog2(LONGEST + 1);

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] cnt_q;
    logic             done_q;
    logic             finish_now;
    int unsigned      code_c;

    // Map the select code to a wait length in ticks.
    always_comb begin
        code_c = clamp_code(int'(sel), MAX_CODE);
        if (code_c == 0)
            limit = '0;
        else
            limit = LIM_W'(BASE) << (code_c - 1);
    end

    // The wait ends now if there is none, or if the last tick arrives.
    always_comb finish_now = !done_q &&
                             ((limit == '0) || (tick && (cnt_q == limit - LIM_W'(1))));

    // Count wait ticks and latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (finish_now) begin
            done_q <= 1'b1;
        end else if (!done_q && tick) begin
            cnt_q <= cnt_q + LIM_W'(1);
        end
    end

    always_comb wait_over = done_q | finish_now;

    // R9: the wait can only end on a tick, or at once for a zero-length wait.
    assert_wait_ends_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(tick) || ($past(limit) == '0)));

endmodule

// File: rtl/wdog_expiry_core.sv
// Module: timeout counter and pulse generator. It counts ticks since the
// last kick, pulses for PULSE_TICKS ticks at expiry, then holds silent
// until a kick re-arms it. A kick in the same cycle as a tick wins.
// Assumes go stays high once raised until clear is asserted.
module wdog_expiry_core #(
    parameter int PERIOD_W    = 18,
    parameter int PULSE_TICKS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                go,
    input  logic                tick,
    input  logic                kick,
    input  logic [PERIOD_W-1:0] period,
    output logic                pulse_o,
    output logic                live_o
);
    import wdog_pkg::*;

    localparam int PC_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

    wd_state_t           state_q;
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] eff_period;
    logic [PERIOD_W-1:0] cnt_inc;
    logic [PC_W-1:0]     pcnt_q;

    // A zero period is treated as one tick.
    always_comb begin
        eff_period = (period == '0) ? PERIOD_W'(1) : period;
        cnt_inc    = cnt_q + PERIOD_W'(1);
    end

    // Main sequence: wait -> run -> pulse -> hold, with kick re-arming.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
            pcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    cnt_q <= '0;
                    if (go) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    if (kick) begin
                        cnt_q <= '0;
                    end else if (tick) begin
                        if (cnt_inc >= eff_period) begin
                            state_q <= ST_PULSE;
                            cnt_q   <= '0;
                            pcnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_inc;
                        end
                    end
                end
                ST_PULSE: begin
                    if (kick) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end else if (tick) begin
                        if (pcnt_q == PC_W'(PULSE_TICKS - 1))
                            state_q <= ST_HOLD;
                        else
                            pcnt_q <= pcnt_q + PC_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (kick) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    // Outputs follow the registered state only.
    always_comb begin
        pulse_o = (state_q == ST_PULSE);
        live_o  = (state_q != ST_WAIT);
    end

    // R3 and R8: a pulse starts only after a tick that carried no kick.
    assert_rise_after_clean_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> ($past(tick) && !$past(kick)));

    // R5: a kick while running restarts the count from zero.
    assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && kick && !clear) |=> (state_q == ST_RUN && cnt_q == '0));

    // R7: once expired, no pulse appears without a kick.
    assert_hold_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !kick && !clear) |=> !pulse_o);

endmodule

// File: rtl/wdog_supervisor.sv
// Module: top of the watchdog. It joins the pin synchronizer, the
// start-wait timer and the expiry core. A kick is a pin change or a
// command strobe. Assumes tick_1ms is a one-cycle pulse per millisecond.
module wdog_supervisor #(
    parameter int PERIOD_W       = 18,
    parameter int SEL_W          = 4,
    parameter int DELAY_BASE     = 100,
    parameter int DELAY_MAX_CODE = 9,
    parameter int PULSE_TICKS    = 1,
    parameter int SYNC_STAGES    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_1ms,
    input  logic                wdi,
    input  logic                kick_cmd,
    input  logic                enable,
    input  logic [PERIOD_W-1:0] period_ms,
    input  logic [SEL_W-1:0]    delay_sel,
    output logic                wdo,
    output logic                monitor_active
);

    logic pin_change;
    logic kick_any;
    logic wait_over;
    logic clear;

    // Disabling the block clears every stage.
    always_comb begin
        clear    = !enable;
        kick_any = pin_change | kick_cmd;
    end

    wdog_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (wdi),
        .change_o (pin_change)
    );

    wdog_start_delay #(
        .SEL_W    (SEL_W),
        .BASE     (DELAY_BASE),
        .MAX_CODE (DELAY_MAX_CODE)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .tick      (tick_1ms),
        .sel       (delay_sel),
        .wait_over (wait_over)
    );

    wdog_expiry_core #(
        .PERIOD_W    (PERIOD_W),
        .PULSE_TICKS (PULSE_TICKS)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .go      (wait_over),
        .tick    (tick_1ms),
        .kick    (kick_any),
        .period  (period_ms),
        .pulse_o (wdo),
        .live_o  (monitor_active)
    );

    // R11: a low enable silences both outputs on the next clock.
    assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!wdo && !monitor_active));

    // R2 and R9: supervision only becomes live while enabled.
    assert_live_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(monitor_active) |-> $past(enable));

endmodule

// File: tb/sim_wdog_supervisor.sv
// Scoreboard bench: driver tasks push expected events (live rise, pulse
// rise, both tagged with a tick number); a monitor pops and compares.
module sim_wdog_supervisor;

    localparam int PW     = 18;
    localparam int PULSES = 2;
    localparam int K_LIVE  = 0;
    localparam int K_PULSE = 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_r = 1'b0;
    logic          wdi;
    logic          kick_cmd;
    logic          enable;
    logic [PW-1:0] period_ms;
    logic [3:0]    delay_sel;
    logic          wdo;
    logic          monitor_active;

    int tick_no = 0;
    int checks = 0;
    int failures = 0;
    int    q_kind[$];
    int    q_tick[$];
    string q_req[$];

    always #5 clk = ~clk;

    // Tick on every other clock; tick_no counts ticks handed to the design.
    always @(negedge clk) begin
        tick_r <= ~tick_r;
        if (!tick_r) tick_no <= tick_no + 1;
    end

    wdog_supervisor #(.PULSE_TICKS(PULSES)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_1ms       (tick_r),
        .wdi            (wdi),
        .kick_cmd       (kick_cmd),
        .enable         (enable),
        .period_ms      (period_ms),
        .delay_sel      (delay_sel),
        .wdo            (wdo),
        .monitor_active (monitor_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int t, input string req);
        q_kind.push_back(kind);
        q_tick.push_back(t);
        q_req.push_back(req);
    endtask

    // Ticks the design will have taken after the coming clock edge.
    function automatic int thru_next();
        return tick_no + (tick_r ? 0 : 1);
    endfunction

    // Command kick; returns the tick count at the edge that takes it.
    task automatic kick_strobe(output int base);
        base = thru_next();
        kick_cmd = 1'b1;
        @(negedge clk);
        kick_cmd = 1'b0;
    endtask

    // Pin change; it lands on the third edge (R4), ticks on edges 1 and 3 or on 2.
    task automatic pin_toggle(output int base);
        base = tick_no + (tick_r ? 1 : 2);
        wdi = ~wdi;
        repeat (3) @(negedge clk);
    endtask

    // Strobe exactly on the edge that takes tick number target.
    task automatic kick_on_tick(input int target);
        while (!(tick_r == 1'b0 && tick_no == target - 1)) @(negedge clk);
        kick_cmd = 1'b1;
        @(negedge clk);
        kick_cmd = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        int t0;
        t0 = tick_no;
        while (tick_no < t0 + n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int guard;
        guard = 0;
        while (q_kind.size() != 0 && guard < 60000) begin
            @(negedge clk);
            guard++;
        end
        chk(q_kind.size() == 0, req, q_kind.size(), 0);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare observed rises with the queue; check pulse width (R6).
    logic wdo_p = 1'b0;
    logic act_p = 1'b0;
    int   rise_at = 0;
    always @(negedge clk) begin
        if (wdo === 1'b1 && wdo_p !== 1'b1) begin
            rise_at = tick_no;
            if (q_kind.size() == 0) chk(1'b0, "unexpected pulse", tick_no, -1);
            else begin
                chk(q_kind[0] == K_PULSE && q_tick[0] == tick_no, q_req[0], tick_no, q_tick[0]);
                void'(q_kind.pop_front()); void'(q_tick.pop_front()); void'(q_req.pop_front());
            end
        end
        if (wdo === 1'b0 && wdo_p === 1'b1 && enable && rst_n)
            chk(tick_no - rise_at == PULSES, "R6 width", tick_no - rise_at, PULSES);
        if (monitor_active === 1'b1 && act_p !== 1'b1) begin
            if (q_kind.size() == 0) chk(1'b0, "unexpected live", tick_no, -1);
            else begin
                chk(q_kind[0] == K_LIVE && q_tick[0] == tick_no, q_req[0], tick_no, q_tick[0]);
                void'(q_kind.pop_front()); void'(q_tick.pop_front()); void'(q_req.pop_front());
            end
        end
        wdo_p = wdo;
        act_p = monitor_active;
    end

    // Watchdog for the run itself.
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int b;
        int ts;
        rst_n = 1'b0; enable = 1'b1; wdi = 1'b0; kick_cmd = 1'b0;
        period_ms = PW'(5); delay_sel = 4'd0;
        repeat (4) @(negedge clk);
        chk(wdo === 1'b0 && monitor_active === 1'b0, "R1 reset state", {wdo, monitor_active}, 0);

        // R2 immediate start, R3 first timeout
        ts = thru_next();
        push(K_LIVE, ts, "R2 live");
        push(K_PULSE, ts + 5, "R3 first expiry");
        rst_n = 1'b1;
        drain("R3 drain");

        // R7 silent after the pulse for a long stretch
        wait_ticks(40);
        chk(wdo === 1'b0 && monitor_active === 1'b1, "R7 hold silent", {wdo, monitor_active}, 1);

        // R5 and R7: command kick re-arms a full period
        kick_strobe(b);
        push(K_PULSE, b + 5, "R5 R7 re-arm");
        drain("R5 drain");

        // R4: rising then falling pin change; each must restart the count
        period_ms = PW'(6);
        kick_strobe(b);
        wait_ticks(3);
        pin_toggle(b);
        wait_ticks(4);
        pin_toggle(b);
        push(K_PULSE, b + 6, "R4 both edges");
        drain("R4 drain");

        // R8: strobe on the very tick that would expire
        kick_strobe(b);
        kick_on_tick(b + 6);
        push(K_PULSE, b + 12, "R8 kick wins");
        drain("R8 drain");

        // R12: zero period acts as one tick
        period_ms = '0;
        kick_strobe(b);
        push(K_PULSE, b + 1, "R12 zero period");
        drain("R12 drain");

        // R11: disable in the middle of a pulse
        period_ms = PW'(5);
        kick_strobe(b);
        push(K_PULSE, b + 5, "R11 pulse before disable");
        while (wdo !== 1'b1) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(wdo === 1'b0 && monitor_active === 1'b0, "R11 disable clears", {wdo, monitor_active}, 0);
        kick_strobe(b);
        repeat (10) @(negedge clk);
        chk(wdo === 1'b0 && monitor_active === 1'b0, "R11 stays off", {wdo, monitor_active}, 0);

        // R9 code 1 and R10 kicks inside the wait are ignored
        delay_sel = 4'd1;
        period_ms = PW'(7);
        ts = tick_no;
        push(K_LIVE, ts + 100, "R9 code 1 wait");
        push(K_PULSE, ts + 107, "R10 wait kicks ignored");
        enable = 1'b1;
        wait_ticks(30);
        kick_strobe(b);
        wait_ticks(30);
        pin_toggle(b);
        wait_ticks(10);
        chk(monitor_active === 1'b0, "R10 still waiting", monitor_active, 0);
        drain("R10 drain");

        // R9 code 3 after a reset
        delay_sel = 4'd3;
        period_ms = PW'(4);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(wdo === 1'b0 && monitor_active === 1'b0, "R1 reset again", {wdo, monitor_active}, 0);
        ts = tick_no;
        push(K_LIVE, ts + 400, "R9 code 3 wait");
        push(K_PULSE, ts + 404, "R9 code 3 expiry");
        rst_n = 1'b1;
        drain("R9 code 3 drain");

        // R9 clamp: code 12 acts as code 9 (25600 ticks); R11 re-enable restarts wait
        enable = 1'b0;
        repeat (2) @(negedge clk);
        delay_sel = 4'd12;
        period_ms = PW'(3);
        ts = tick_no;
        push(K_LIVE, ts + 25600, "R9 clamp wait");
        push(K_PULSE, ts + 25603, "R9 clamp expiry");
        enable = 1'b1;
        drain("R9 clamp drain");

        chk(q_kind.size() == 0, "scoreboard empty", q_kind.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule